// File: doc/BRIEF.md
# Chained Transfer Descriptor Walker

This block follows a linked list of transfer descriptors held in memory on behalf of one transfer channel. The channel holds a pointer to the next descriptor. When the transfer engine asks for the next descriptor, the walker reads four 32-bit words through a single-outstanding memory port and unpacks them into the channel's working registers: control flags, total size, source address, destination address and the link to the following descriptor. It also reports whether the list continues past the descriptor just loaded.

The engine stalls while `busy` is high and continues on the single-cycle `done` pulse. At final termination the engine can ask the walker to write the remaining word count back into the control word of the descriptor that was last loaded. The walker does this only when size write-back and descriptor mode are both enabled. Channel arbitration and the data movement itself belong to other blocks.

Top module: `ll_desc_walker`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `mem_req`, `mem_we` and `chain_more` are 0, and the pointer, current-descriptor, address, size and flag outputs are all 0.
- R2: A `fetch_req` seen while idle causes exactly four reads, one at a time, at pointer+0x0, +0x4, +0x8 and +0xC in that order. Each request's address and direction stay unchanged until `mem_ack` accepts it.
- R3: `busy` is high from the cycle after an accepted request until the operation ends. `done` is a one-cycle pulse in the cycle after the last memory access is acknowledged, and `busy` is already low in that cycle.
- R4: Control-word bits 16, 17, 18 and 19 (source increment, destination increment, source select, destination select) appear on `inc_src`, `inc_dst`, `sel_src` and `sel_dst`.
- R5: Control-word bits 11:0 appear on `tot_size`.
- R6: The second word fetched appears on `src_addr` and the third on `dst_addr`.
- R7: After a fetch, `cur_desc` equals the pointer the fetch started from, and `desc_ptr` equals the fourth word fetched.
- R8: `chain_more` is the inverse of control-word bit 20, the end-of-list flag.
- R9: A `wb_req` seen while idle, with `wb_en` and `desc_mode` both 1, causes one write to `cur_desc`+0x0. The written word is the last fetched control word with bits 11:0 replaced by `tot_size - xfer_count` (modulo 4096). `tot_size` then takes that remaining count, and `done` pulses.
- R10: A `wb_req` with `wb_en` or `desc_mode` at 0 is ignored. No memory access follows, no `done` pulse follows, and `tot_size` is unchanged.
- R11: A `fetch_req` that arrives while busy is ignored. When `fetch_req` and `wb_req` arrive in the same idle cycle, the fetch is performed and the write-back request is dropped.
- R12: `ptr_load` while idle sets `desc_ptr` to `ptr_wdata` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | Engine asks for the next descriptor |
| wb_req | input | 1 | Engine signals final termination (write-back candidate) |
| wb_en | input | 1 | Size write-back enabled for the channel |
| desc_mode | input | 1 | Channel operates from descriptors |
| xfer_count | input | 12 | Words transferred in the finished run |
| ptr_load | input | 1 | Software load of the descriptor pointer |
| ptr_wdata | input | 32 | Pointer value to load |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access accepted / read data valid |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Fetch or write-back in progress |
| done | output | 1 | One-cycle completion pulse |
| inc_src | output | 1 | Source address increments |
| inc_dst | output | 1 | Destination address increments |
| sel_src | output | 1 | Source port select |
| sel_dst | output | 1 | Destination port select |
| tot_size | output | 12 | Total transfer size in words |
| src_addr | output | 32 | Source address |
| dst_addr | output | 32 | Destination address |
| cur_desc | output | 32 | Address of the descriptor last loaded |
| desc_ptr | output | 32 | Pointer to the next descriptor |
| chain_more | output | 1 | Another descriptor follows |

## Verification
A wrong word index shows up in the first cycle of the mismatched access. The logged read addresses leave the +0/+4/+8/+C order, or a field lands on the wrong output once `done` pulses. A wrong state, such as a stuck write-back or a re-triggered fetch, shows on the memory port at once as an extra access or a missing `done`. A stale pointer or current-descriptor register is exposed on the next fetch: the list is walked through two linked descriptors, and a write-back is then aimed at the second one. The sweep covers every combination of the four flags, three acknowledge latencies, and both the positive and the ignored write-back cases.

// File: rtl/ldw_pkg.sv
package ldw_pkg;

    localparam int WORD_W     = 32;
    localparam int SIZE_W     = 12;
    localparam int DESC_WORDS = 4;
    localparam int IDX_W      = $clog2(DESC_WORDS);
    localparam int HI_W       = WORD_W - SIZE_W;

    localparam int BIT_INC_SRC = 16;
    localparam int BIT_INC_DST = 17;
    localparam int BIT_SEL_SRC = 18;
    localparam int BIT_SEL_DST = 19;
    localparam int BIT_EOL     = 20;

    localparam logic [IDX_W-1:0] IDX_CTRL = IDX_W'(0);
    localparam logic [IDX_W-1:0] IDX_SRC  = IDX_W'(1);
    localparam logic [IDX_W-1:0] IDX_DST  = IDX_W'(2);
    localparam logic [IDX_W-1:0] IDX_LINK = IDX_W'(DESC_WORDS - 1);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WBACK = 2'd2
    } walk_state_e;

    typedef struct packed {
        logic sel_dst;
        logic sel_src;
        logic inc_dst;
        logic inc_src;
    } xfer_flags_t;

    typedef struct packed {
        xfer_flags_t             flags;
        logic                    eol;
        logic [SIZE_W-1:0]       size;
        logic [HI_W-1:0]         upper;
    } ctrl_fields_t;

    function automatic ctrl_fields_t split_ctrl(input logic [WORD_W-1:0] w);
        ctrl_fields_t f;
        f.flags.inc_src = w[BIT_INC_SRC];
        f.flags.inc_dst = w[BIT_INC_DST];
        f.flags.sel_src = w[BIT_SEL_SRC];
        f.flags.sel_dst = w[BIT_SEL_DST];
        f.eol           = w[BIT_EOL];
        f.size          = w[SIZE_W-1:0];
        f.upper         = w[WORD_W-1:SIZE_W];
        return f;
    endfunction

    function automatic logic [WORD_W-1:0] word_offset(input logic [IDX_W-1:0] idx);
        return WORD_W'({idx, 2'b00});
    endfunction

endpackage

// File: rtl/ldw_seq.sv
module ldw_seq
    import ldw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fetch_req,
    input  logic             wb_req,
    input  logic             wb_allowed,
    input  logic             mem_ack,
    output logic             busy,
    output logic             done,
    output logic             mem_req,
    output logic             mem_we,
    output logic             in_wback,
    output logic [IDX_W-1:0] word_idx,
    output logic             cap_stb,
    output logic             wb_stb
);

    walk_state_e      state_q;
    logic [IDX_W-1:0] idx_q;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (fetch_req) begin
                        state_q <= ST_READ;
                        idx_q   <= IDX_CTRL;
                    end else if (wb_req && wb_allowed) begin
                        state_q <= ST_WBACK;
                    end
                end
                ST_READ: begin
                    if (mem_ack) begin
                        if (idx_q == IDX_LINK) begin
                            state_q <= ST_IDLE;
                            idx_q   <= '0;
                            done_q  <= 1'b1;
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                        end
                    end
                end
                ST_WBACK: begin
                    if (mem_ack) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy     = (state_q != ST_IDLE);
        mem_req  = (state_q == ST_READ) || (state_q == ST_WBACK);
        mem_we   = (state_q == ST_WBACK);
        in_wback = (state_q == ST_WBACK);
        word_idx = idx_q;
        cap_stb  = (state_q == ST_READ) && mem_ack;
        wb_stb   = (state_q == ST_WBACK) && mem_ack;
        done     = done_q;
    end

endmodule

// File: rtl/ldw_regs.sv
module ldw_regs
    import ldw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              idle,
    input  logic              ptr_load,
    input  logic [WORD_W-1:0] ptr_wdata,
    input  logic              cap_stb,
    input  logic [IDX_W-1:0]  word_idx,
    input  logic [WORD_W-1:0] rdata,
    input  logic              wb_stb,
    input  logic              in_wback,
    input  logic [SIZE_W-1:0] xfer_count,
    output xfer_flags_t       flags,
    output logic [SIZE_W-1:0] tot_size,
    output logic [WORD_W-1:0] src_addr,
    output logic [WORD_W-1:0] dst_addr,
    output logic [WORD_W-1:0] cur_desc,
    output logic [WORD_W-1:0] desc_ptr,
    output logic              chain_more,
    output logic [WORD_W-1:0] acc_addr,
    output logic [WORD_W-1:0] wb_word
);

    ctrl_fields_t      fields;
    logic [HI_W-1:0]   upper_q;
    logic [SIZE_W-1:0] remaining;

    always_comb begin
        fields    = split_ctrl(rdata);
        remaining = tot_size - xfer_count;
        wb_word   = {upper_q, remaining};
        acc_addr  = in_wback ? cur_desc : (desc_ptr + word_offset(word_idx));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags      <= '0;
            tot_size   <= '0;
            src_addr   <= '0;
            dst_addr   <= '0;
            cur_desc   <= '0;
            desc_ptr   <= '0;
            chain_more <= 1'b0;
            upper_q    <= '0;
        end else if (cap_stb) begin
            unique case (word_idx)
                IDX_CTRL: begin
                    flags      <= fields.flags;
                    tot_size   <= fields.size;
                    chain_more <= ~fields.eol;
                    upper_q    <= fields.upper;
                end
                IDX_SRC: src_addr <= rdata;
                IDX_DST: dst_addr <= rdata;
                default: begin
                    cur_desc <= desc_ptr;
                    desc_ptr <= rdata;
                end
            endcase
        end else if (wb_stb) begin
            tot_size <= remaining;
        end else if (idle && ptr_load) begin
            desc_ptr <= ptr_wdata;
        end
    end

endmodule

// File: rtl/ll_desc_walker.sv
module ll_desc_walker
    import ldw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_req,
    input  logic              wb_req,
    input  logic              wb_en,
    input  logic              desc_mode,
    input  logic [SIZE_W-1:0] xfer_count,
    input  logic              ptr_load,
    input  logic [WORD_W-1:0] ptr_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              inc_src,
    output logic              inc_dst,
    output logic              sel_src,
    output logic              sel_dst,
    output logic [SIZE_W-1:0] tot_size,
    output logic [WORD_W-1:0] src_addr,
    output logic [WORD_W-1:0] dst_addr,
    output logic [WORD_W-1:0] cur_desc,
    output logic [WORD_W-1:0] desc_ptr,
    output logic              chain_more
);

    logic             in_wback;
    logic [IDX_W-1:0] word_idx;
    logic             cap_stb;
    logic             wb_stb;
    xfer_flags_t      flags;

    ldw_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .fetch_req  (fetch_req),
        .wb_req     (wb_req),
        .wb_allowed (wb_en && desc_mode),
        .mem_ack    (mem_ack),
        .busy       (busy),
        .done       (done),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .in_wback   (in_wback),
        .word_idx   (word_idx),
        .cap_stb    (cap_stb),
        .wb_stb     (wb_stb)
    );

    ldw_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .idle       (!busy),
        .ptr_load   (ptr_load),
        .ptr_wdata  (ptr_wdata),
        .cap_stb    (cap_stb),
        .word_idx   (word_idx),
        .rdata      (mem_rdata),
        .wb_stb     (wb_stb),
        .in_wback   (in_wback),
        .xfer_count (xfer_count),
        .flags      (flags),
        .tot_size   (tot_size),
        .src_addr   (src_addr),
        .dst_addr   (dst_addr),
        .cur_desc   (cur_desc),
        .desc_ptr   (desc_ptr),
        .chain_more (chain_more),
        .acc_addr   (mem_addr),
        .wb_word    (mem_wdata)
    );

    always_comb begin
        inc_src = flags.inc_src;
        inc_dst = flags.inc_dst;
        sel_src = flags.sel_src;
        sel_dst = flags.sel_dst;
    end

endmodule

// File: rtl/ll_desc_walker_chk.sv
module ll_desc_walker_chk (
    input logic        clk,
    input logic        rst,
    input logic        fetch_req,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic        mem_ack,
    input logic        busy,
    input logic        done,
    input logic [31:0] desc_ptr
);

    // R3: completion is a single-cycle pulse
    a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3: busy has dropped by the time done is seen
    a_r3_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R3: done follows a busy cycle
    a_r3_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

    // R2: an unacknowledged request holds address and direction
    a_r2_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R11: an operation in flight cannot be cut short by new requests
    a_r11_busy_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && !mem_ack) |=> busy);

    // R7: the pointer is not disturbed mid-operation without an acknowledge
    a_r7_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && !mem_ack) |=> $stable(desc_ptr));

    // R2: a memory request only starts from an accepted fetch or write-back
    a_r2_req_start: assert property (@(posedge clk) disable iff (rst)
        ($rose(mem_req) && !mem_we) |-> $past(fetch_req));

endmodule

bind ll_desc_walker ll_desc_walker_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .fetch_req (fetch_req),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .busy      (busy),
    .done      (done),
    .desc_ptr  (desc_ptr)
);

// File: tb/ll_desc_walker_tb_top.sv
module ll_desc_walker_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_req = 1'b0;
    logic        wb_req = 1'b0;
    logic        wb_en = 1'b0;
    logic        desc_mode = 1'b0;
    logic [11:0] xfer_count = '0;
    logic        ptr_load = 1'b0;
    logic [31:0] ptr_wdata = '0;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        busy;
    logic        done;
    logic        inc_src;
    logic        inc_dst;
    logic        sel_src;
    logic        sel_dst;
    logic [11:0] tot_size;
    logic [31:0] src_addr;
    logic [31:0] dst_addr;
    logic [31:0] cur_desc;
    logic [31:0] desc_ptr;
    logic        chain_more;

    always #10 clk = ~clk;

    ll_desc_walker dut_i (
        .clk        (clk),
        .rst        (rst),
        .fetch_req  (fetch_req),
        .wb_req     (wb_req),
        .wb_en      (wb_en),
        .desc_mode  (desc_mode),
        .xfer_count (xfer_count),
        .ptr_load   (ptr_load),
        .ptr_wdata  (ptr_wdata),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .busy       (busy),
        .done       (done),
        .inc_src    (inc_src),
        .inc_dst    (inc_dst),
        .sel_src    (sel_src),
        .sel_dst    (sel_dst),
        .tot_size   (tot_size),
        .src_addr   (src_addr),
        .dst_addr   (dst_addr),
        .cur_desc   (cur_desc),
        .desc_ptr   (desc_ptr),
        .chain_more (chain_more)
    );

    logic [31:0] mem [0:255];
    logic [31:0] acc_log [0:7];
    logic        acc_we [0:7];
    int          n_acc = 0;
    int          n_done = 0;
    int          lat = 0;
    int          wait_cnt = 0;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          finished = 1'b0;

    // memory responder, acts on falling edges
    always @(negedge clk) begin
        if (done) n_done = n_done + 1;
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (wait_cnt >= lat) begin
                mem_ack = 1'b1;
                if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
                else        mem_rdata = mem[mem_addr[9:2]];
                if (n_acc < 8) begin
                    acc_log[n_acc] = mem_addr;
                    acc_we[n_acc]  = mem_we;
                end
                n_acc    = n_acc + 1;
                wait_cnt = 0;
            end else begin
                wait_cnt = wait_cnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec = n_vec + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic wait_done();
        int guard = 0;
        while (!done && guard < 100) begin
            @(negedge clk);
            guard = guard + 1;
        end
    endtask

    task automatic fetch(input int hold, input bit with_wb);
        n_acc  = 0;
        n_done = 0;
        @(negedge clk);
        fetch_req = 1'b1;
        if (with_wb) begin
            wb_req = 1'b1; wb_en = 1'b1; desc_mode = 1'b1;
        end
        @(negedge clk);
        wb_req = 1'b0;
        chk(busy == 1'b1, "R3", "busy after request", 32'(busy), 32'd1);
        for (int i = 1; i < hold; i++) @(negedge clk);
        fetch_req = 1'b0;
        wait_done();
        chk(done == 1'b1, "R3", "done pulse", 32'(done), 32'd1);
        chk(busy == 1'b0, "R3", "busy low at done", 32'(busy), 32'd0);
        @(negedge clk);
        chk(done == 1'b0, "R3", "done width", 32'(done), 32'd0);
        wb_en = 1'b0; desc_mode = 1'b0;
    endtask

    task automatic check_reads(input logic [31:0] base, input string req);
        chk(n_acc == 4, req, "read count", 32'(n_acc), 32'd4);
        chk(n_done == 1, req, "done count", 32'(n_done), 32'd1);
        for (int i = 0; i < 4; i++) begin
            chk(acc_log[i] == base + 32'(4 * i) && !acc_we[i], "R2", "read order",
                acc_log[i], base + 32'(4 * i));
        end
    endtask

    task automatic check_desc(input logic [31:0] base, input logic [31:0] ctrl,
                              input logic [31:0] s, input logic [31:0] d,
                              input logic [31:0] nxt);
        chk({sel_dst, sel_src, inc_dst, inc_src} == ctrl[19:16], "R4", "flags",
            32'({sel_dst, sel_src, inc_dst, inc_src}), 32'(ctrl[19:16]));
        chk(tot_size == ctrl[11:0], "R5", "size", 32'(tot_size), 32'(ctrl[11:0]));
        chk(src_addr == s, "R6", "src", src_addr, s);
        chk(dst_addr == d, "R6", "dst", dst_addr, d);
        chk(cur_desc == base, "R7", "cur_desc", cur_desc, base);
        chk(desc_ptr == nxt, "R7", "desc_ptr", desc_ptr, nxt);
        chk(chain_more == ~ctrl[20], "R8", "chain_more", 32'(chain_more), 32'(~ctrl[20]));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(!busy && !done && !mem_req && !mem_we && !chain_more, "R1", "control outs",
            32'({busy, done, mem_req, mem_we, chain_more}), 32'd0);
        chk(desc_ptr == 0 && cur_desc == 0 && src_addr == 0 && dst_addr == 0, "R1",
            "address outs", desc_ptr | cur_desc | src_addr | dst_addr, 32'd0);
        chk(tot_size == 0 && {inc_src, inc_dst, sel_src, sel_dst} == 0, "R1", "size/flags",
            32'({tot_size, inc_src, inc_dst, sel_src, sel_dst}), 32'd0);

        for (int t = 0; t < 16; t++) begin
            logic [31:0] a, b, c0, c1, nx1, wexp;
            logic [11:0] s0, s1, k, rem;
            lat = t % 3;
            a  = 32'h80 + 32'(t * 32);
            b  = a + 32'h10;
            s0 = 12'((t * 37 + 5) % 4096);
            s1 = 12'((t * 91 + 300) % 4096);
            c0 = {11'(t + 1), 1'b0, 4'(t), 4'(~t), s0};
            c1 = {11'(t * 3), 1'b1, 4'(~t), 4'(t), s1};
            nx1 = 32'hFF00_0000 | 32'(t);
            mem[a[9:2]]     = c0;
            mem[a[9:2] + 1] = 32'h1000_0000 + 32'(t);
            mem[a[9:2] + 2] = 32'h2000_0000 + 32'(t * 16);
            mem[a[9:2] + 3] = b;
            mem[b[9:2]]     = c1;
            mem[b[9:2] + 1] = 32'h3000_0000 + 32'(t);
            mem[b[9:2] + 2] = 32'h4000_0000 + 32'(t * 8);
            mem[b[9:2] + 3] = nx1;

            // R12 pointer load while idle
            @(negedge clk);
            ptr_load = 1'b1; ptr_wdata = a;
            @(negedge clk);
            ptr_load = 1'b0;
            chk(desc_ptr == a, "R12", "pointer load", desc_ptr, a);

            // first descriptor; R11 held request and simultaneous write-back request
            fetch((t % 2 == 1) ? 3 : 1, (t % 4 == 2));
            check_reads(a, "R11");
            check_desc(a, c0, 32'h1000_0000 + 32'(t), 32'h2000_0000 + 32'(t * 16), b);

            // second, final descriptor
            fetch(1, 1'b0);
            check_reads(b, "R2");
            check_desc(b, c1, 32'h3000_0000 + 32'(t), 32'h4000_0000 + 32'(t * 8), nx1);

            // R10 write-back with one enable low is ignored
            n_acc = 0; n_done = 0;
            @(negedge clk);
            wb_req = 1'b1; wb_en = t[0]; desc_mode = ~t[0]; xfer_count = 12'(t);
            @(negedge clk);
            wb_req = 1'b0;
            repeat (6) @(negedge clk);
            chk(n_acc == 0 && n_done == 0, "R10", "no access", 32'(n_acc + n_done), 32'd0);
            chk(mem[b[9:2]] == c1, "R10", "memory unchanged", mem[b[9:2]], c1);
            chk(tot_size == s1, "R10", "size unchanged", 32'(tot_size), 32'(s1));

            // R9 write-back with both enables
            k    = 12'(t * 5 + 1);
            rem  = s1 - k;
            wexp = {c1[31:12], rem};
            n_acc = 0; n_done = 0;
            @(negedge clk);
            wb_req = 1'b1; wb_en = 1'b1; desc_mode = 1'b1; xfer_count = k;
            @(negedge clk);
            wb_req = 1'b0;
            chk(busy == 1'b1, "R9", "busy during write", 32'(busy), 32'd1);
            wait_done();
            chk(done == 1'b1 && busy == 1'b0, "R9", "done after write",
                32'({done, busy}), 32'd2);
            @(negedge clk);
            wb_en = 1'b0; desc_mode = 1'b0;
            chk(n_acc == 1 && acc_we[0] && acc_log[0] == b, "R9", "write address",
                acc_log[0], b);
            chk(mem[b[9:2]] == wexp, "R9", "written word", mem[b[9:2]], wexp);
            chk(tot_size == rem, "R9", "size updated", 32'(tot_size), 32'(rem));
            chk(n_done == 1, "R9", "done count", 32'(n_done), 32'd1);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule